// File: doc/BRIEF.md
# Horizontal Pixel Clip Unit

The unit sits in a display pixel pipeline. It takes lines that are as wide as the framebuffer and forwards only a programmable horizontal window of each line. Every pixel whose index falls outside the window is dropped, and so is every pixel beyond the window's right edge. A bypass mode passes the stream through untouched. Vertical cropping is not done: every input line yields exactly one output line.

Configuration arrives through a simple write port into shadow registers:

- A bypass flag.
- A size word. Width minus one sits in the upper half and height minus one in the lower half.
- A clip word. The left clip amount sits in the upper half and the right clip value in the lower half.

The shadow contents move into the active set only at a frame start. A freeze flag blocks that transfer, so a whole set of writes can be staged and released together.

Both streams use valid/ready handshakes. A beat is transferred on a rising edge where valid and ready are both high. The output holds its beat stable while it waits for ready. Input ready depends only on state and the current beat's marker. It does not depend on `in_valid`. Pixels that are being discarded are always accepted, so clipping never adds stalls. A forwarded pixel appears one cycle after it is accepted.

Top module: `hclip_top`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, the freeze flag is clear, and bypass is active.
- R2: In bypass, every input beat is forwarded unchanged, with its own `sof` and `eol` markers, one cycle after acceptance.
- R3: In clip mode the pixel at line index x is forwarded exactly when x ≥ L and x ≤ (Wm1 − R − 1) mod 2^16. Wm1 is bits 31:16 of the size word (address 1). L is bits 31:16 and R is bits 15:0 of the clip word (address 2). Bit 0 at address 0 selects bypass when it is 1.
- R4: In clip mode the output `eol` is set on the last forwarded pixel of each line. The output `sof` is set on the first forwarded pixel of each frame.
- R5: While the current input pixel lies outside the window, `in_ready` is high whatever `out_ready` is.
- R6: Writes go to shadow registers. The shadow set becomes active on the accepted beat carrying `in_sof`, and that beat already uses it. Writes made during a frame do not change the frame in progress.
- R7: While bit 0 at address 3 (freeze) is 1, frame starts keep the active set. After the flag is cleared, the staged values take effect at the next frame start.
- R8: No line is removed. The number of output `eol` markers in a frame equals the number of input lines.
- R9: While `out_valid` is high and `out_ready` is low, the output beat holds stable. No pixel is lost or duplicated under back-pressure.
- R10: A right clip value of 16'hFFFF with L = 0 in clip mode forwards the full line, and `eol` falls on the pixel at index Wm1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 bypass, 1 size, 2 clip, 3 freeze |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of an input line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_data | output | PIX_W | Output pixel |
| out_sof | output | 1 | First forwarded pixel of a frame |
| out_eol | output | 1 | Last forwarded pixel of a line |

## Verification
The assertions make three assumptions about the input side:

- Every input line is exactly Wm1+1 pixels long.
- The window is non-empty and ends no later than the line does.
- A frame never has more lines than the programmed height.

The stimulus meets these by drawing the left clip and the window width so that their sum never exceeds the line width. It derives the right value from them by the signed formula. It also programs a height of three lines while sending at most three lines per frame. Register writes are made only between frames, except for the one deliberate mid-frame write, which lands after the frame's first beat has been accepted.

// File: rtl/hclip_pkg.sv
package hclip_pkg;
  localparam int DIM_W = 16;
  typedef logic [DIM_W-1:0] dim_t;

  typedef struct packed {
    logic bypass;
    dim_t wid_m1;
    dim_t hgt_m1;
    dim_t left;
    dim_t right;
  } clip_cfg_t;

  localparam logic [1:0] A_BYP  = 2'd0;
  localparam logic [1:0] A_SIZE = 2'd1;
  localparam logic [1:0] A_CLIP = 2'd2;
  localparam logic [1:0] A_FRZ  = 2'd3;

  localparam clip_cfg_t CFG_RST = '{bypass: 1'b1, default: '0};
endpackage

// File: rtl/hclip_regs.sv
module hclip_regs
  import hclip_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  logic        sof_now,
  input  logic        sof_take,
  output clip_cfg_t   cfg_eff
);
  clip_cfg_t shadow, active;
  logic      freeze;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= CFG_RST;
      active <= CFG_RST;
      freeze <= 1'b0;
    end else begin
      if (we) begin
        case (addr)
          A_BYP:  shadow.bypass <= wdata[0];
          A_SIZE: begin
            shadow.wid_m1 <= wdata[31:16];
            shadow.hgt_m1 <= wdata[15:0];
          end
          A_CLIP: begin
            shadow.left  <= wdata[31:16];
            shadow.right <= wdata[15:0];
          end
          default: freeze <= wdata[0];
        endcase
      end
      if (sof_take && !freeze) active <= shadow;
    end
  end

  // The frame-start beat already sees the values it loads.
  always_comb cfg_eff = (sof_now && !freeze) ? shadow : active;
endmodule

// File: rtl/hclip_window.sv
module hclip_window
  import hclip_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  clip_cfg_t cfg,
  input  logic      in_sof,
  input  logic      in_eol,
  input  logic      take,
  output logic      keep,
  output logic      last_hit,
  output logic      sof_mark,
  output dim_t      x_now
);
  dim_t xpos;
  dim_t last_x;
  logic pend_sof;

  always_comb begin
    x_now    = in_sof ? '0 : xpos;
    last_x   = cfg.wid_m1 - cfg.right - dim_t'(1);
    keep     = cfg.bypass | ((x_now >= cfg.left) && (x_now <= last_x));
    last_hit = cfg.bypass ? in_eol : (x_now == last_x);
    sof_mark = cfg.bypass ? in_sof : (in_sof | pend_sof);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xpos     <= '0;
      pend_sof <= 1'b0;
    end else if (take) begin
      xpos <= in_eol ? '0 : x_now + dim_t'(1);
      if (keep)        pend_sof <= 1'b0;
      else if (in_sof) pend_sof <= 1'b1;
    end
  end
endmodule

// File: rtl/hclip_ostage.sv
module hclip_ostage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PIX_W-1:0] d,
  input  logic             sof,
  input  logic             eol,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol,
  output logic             can_take
);
  always_comb can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (can_take) begin
      out_valid <= ld;
      if (ld) begin
        out_data <= d;
        out_sof  <= sof;
        out_eol  <= eol;
      end
    end
  end
endmodule

// File: rtl/hclip_top.sv
module hclip_top
  import hclip_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol
);
  clip_cfg_t cfg_eff;
  logic      keep, last_hit, sof_mark, can_take, take;
  dim_t      x_now;

  assign in_ready = !keep || can_take;
  assign take     = in_valid && in_ready;

  hclip_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sof_now(in_sof), .sof_take(take && in_sof), .cfg_eff(cfg_eff)
  );

  hclip_window u_win (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_eff), .in_sof(in_sof), .in_eol(in_eol),
    .take(take), .keep(keep), .last_hit(last_hit), .sof_mark(sof_mark),
    .x_now(x_now)
  );

  hclip_ostage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ld(in_valid && keep), .d(in_data),
    .sof(sof_mark), .eol(last_hit), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol), .can_take(can_take)
  );
endmodule

// File: rtl/hclip_chk.sv
module hclip_chk
  import hclip_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_data,
  input logic             in_sof,
  input logic             in_eol,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             out_sof,
  input logic             out_eol,
  input logic             keep,
  input dim_t             x_now,
  input clip_cfg_t        cfg
);
  dim_t        last_c;
  logic [16:0] line_cnt;

  assign last_c = cfg.wid_m1 - cfg.right - dim_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) line_cnt <= '0;
    else if (out_valid && out_ready)
      line_cnt <= (out_sof ? 17'd0 : line_cnt) + {16'd0, out_eol};
  end

  p_discard_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !keep |-> in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_sof) && $stable(out_eol));

  p_bypass_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cfg.bypass |=> out_valid
      && out_data == $past(in_data) && out_sof == $past(in_sof)
      && out_eol == $past(in_eol));

  p_last_eol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && keep && !cfg.bypass && x_now == last_c
      |=> out_valid && out_eol);

  p_frame_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt <= {1'b0, cfg.hgt_m1} + 17'd1);
endmodule

bind hclip_top hclip_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eol(out_eol), .keep(keep), .x_now(x_now),
  .cfg(cfg_eff)
);

// File: tb/hclip_top_test.sv
module hclip_top_test;
  import hclip_pkg::*;
  localparam int PIX_W      = 24;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, out_ready = 1'b0;
  logic [PIX_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [PIX_W-1:0] out_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [PIX_W-1:0] d;
    logic s;
    logic e;
  } beat_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  hclip_top #(.PIX_W(PIX_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int last_idx(int w, int right);
    return (w - 1 - right - 1) & 16'hFFFF;
  endfunction

  function automatic bit in_win(int x, bit byp, int left, int right, int w);
    if (byp) return 1'b1;
    return (x >= left) && (x <= last_idx(w, right));
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(int w, int lines, bit byp, int left, int right,
                            string req, bit mid, logic [1:0] ma, logic [31:0] md);
    beat_t inq[$];
    beat_t expq[$];
    int xq[$];
    bit first = 1'b1, wrote = 1'b0;
    int got_eol = 0, cyc = 0, acc = 0;
    for (int l = 0; l < lines; l++) begin
      for (int x = 0; x < w; x++) begin
        beat_t b;
        b.d = PIX_W'($urandom);
        b.s = (l == 0 && x == 0);
        b.e = (x == w - 1);
        inq.push_back(b);
        xq.push_back(x);
        if (in_win(x, byp, left, right, w)) begin
          beat_t e;
          e.d = b.d;
          e.s = byp ? b.s : first;
          e.e = byp ? b.e : (x == last_idx(w, right));
          first = 1'b0;
          expq.push_back(e);
        end
      end
    end
    while ((inq.size() > 0 || expq.size() > 0) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      cfg_we = 1'b0;
      if (mid && !wrote && acc >= 3) begin
        cfg_we = 1'b1; cfg_addr = ma; cfg_wdata = md; wrote = 1'b1;
      end
      if (inq.size() > 0) begin
        in_valid = ($urandom_range(3) != 0);
        {in_data, in_sof, in_eol} = inq[0];
      end else in_valid = 1'b0;
      out_ready = ($urandom_range(3) != 0);
      #1;
      if (in_valid && !in_win(xq[0], byp, left, right, w))
        check(in_ready == 1'b1, "R5", "ready on discarded pixel", in_ready, 1);
      if (in_valid && in_ready) begin
        void'(inq.pop_front());
        void'(xq.pop_front());
        acc++;
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(1'b0, req, "unexpected output beat", out_data, 0);
        else begin
          beat_t e = expq.pop_front();
          check({out_data, out_sof, out_eol} == e, req, "output beat {data,sof,eol}",
                {out_data, out_sof, out_eol}, e);
        end
        if (out_eol) got_eol++;
      end
    end
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    check(cyc < 5000, req, "frame watchdog cycles", cyc, 5000);
    check(got_eol == lines, "R8", "output lines per frame", got_eol, lines);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R1 R2: reset default is bypass
    wr(A_SIZE, {16'd9, 16'd2});
    send_frame(10, 2, 1'b1, 0, 0, "R2", 1'b0, 2'd0, 32'd0);

    // R3 R4 R9: random windows under back-pressure
    for (int i = 0; i < 8; i++) begin
      int w = $urandom_range(20, 8);
      int left = $urandom_range(3, 0);
      int ww = $urandom_range(w - left, 1);
      int right = (w - (left + ww) - 1) & 16'hFFFF;
      int lines = $urandom_range(3, 1);
      wr(A_SIZE, {16'(w - 1), 16'd2});
      wr(A_CLIP, {16'(left), 16'(right)});
      wr(A_BYP, 32'd0);
      send_frame(w, lines, 1'b0, left, right, "R3_R4_R9", 1'b0, 2'd0, 32'd0);
    end

    // R10: full-width window through the wrap of the right field
    wr(A_SIZE, {16'd11, 16'd2});
    wr(A_CLIP, {16'd0, 16'hFFFF});
    send_frame(12, 2, 1'b0, 0, 16'hFFFF, "R10", 1'b0, 2'd0, 32'd0);

    // R6: mid-frame write affects only the next frame
    wr(A_SIZE, {16'd15, 16'd2});
    wr(A_CLIP, {16'd2, 16'd3});
    send_frame(16, 3, 1'b0, 2, 3, "R6", 1'b1, A_CLIP, {16'd5, 16'd1});
    send_frame(16, 2, 1'b0, 5, 1, "R6", 1'b0, 2'd0, 32'd0);

    // R7: freeze holds the active set
    wr(A_FRZ, 32'd1);
    wr(A_CLIP, {16'd1, 16'd6});
    send_frame(16, 2, 1'b0, 5, 1, "R7", 1'b0, 2'd0, 32'd0);
    wr(A_FRZ, 32'd0);
    send_frame(16, 2, 1'b0, 1, 6, "R7", 1'b0, 2'd0, 32'd0);

    // R2: return to bypass
    wr(A_BYP, 32'd1);
    send_frame(16, 3, 1'b1, 0, 0, "R2", 1'b0, 2'd0, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule